// File: doc/BRIEF.md
# Asynchronous Bus Register Slave

This block lets an external processor write and read a small bank of registers over an SRAM-style asynchronous bus with active-low chip select, write strobe and read strobe, an address bus and a data bus. No bus strobe is ever used as a clock. All strobe pins are oversampled by a fast local clock (nominally 100 MHz) through two-flop synchronizers. Address and data pass through a matching delay pipeline, so every sample stays aligned with the strobes it belongs to.

A write is recognized only while the synchronized chip select and write strobe are both asserted. Either one may assert first. Whichever assertion comes later opens the write window, and whichever release comes first closes it. While the window is open, address and data are re-captured on every clock. When the window closes, the last captured pair is committed to the register bank, and a one-cycle write-valid pulse carries that pair to the internal logic. A write strobe that toggles while chip select is inactive has no effect, including a short splinter pulse.

A read runs while chip select and the read strobe are both asserted. During a read, the addressed register is driven on a registered read-data output together with a read-enable flag.

Top module: `xbus_reg_slave`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, `wr_valid` and `rd_en` are 0 and `rd_data` is 0.
- R2: Each interval in which the synchronized `bus_cs_n` and `bus_we_n` are both low produces exactly one write. The write commits when that interval ends. It appears as a single-cycle `wr_valid` pulse carrying `wr_addr` and `wr_data`, and the same value is written into the register bank.
- R3: A write commits with the same result whether chip select falls first, write falls first, or both fall together.
- R4: A low pulse on `bus_we_n` while `bus_cs_n` is high produces no `wr_valid` and leaves every register unchanged. This holds for a pulse of several clocks and for a splinter shorter than one clock.
- R5: If `bus_we_n` stays low across one chip-select assertion, exactly one write is committed. If it stays low across two separate chip-select assertions, exactly two writes are committed, each with its own data.
- R6: If data changes while the write window is open, the value present just before the window closes is the one committed.
- R7: The bank has `NUM_REGS` (8) registers indexed by the low address bits, so address values 0 to 7 are valid. A write to any address whose higher bits are not all zero (for example address 8) gives no `wr_valid` and changes no register.
- R8: While `bus_cs_n` and `bus_oe_n` are both low, `rd_en` is 1 and `rd_data` equals the addressed register, valid by the third rising clock edge after the pins assert. A read of an out-of-range address returns 0.
- R9: `rd_en` returns to 0 by the third rising clock edge after either `bus_cs_n` or `bus_oe_n` goes high.
- R10: `wr_valid` is never asserted more than three clock cycles after `bus_cs_n` was last sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Bus chip select, active low, asynchronous |
| bus_we_n | input | 1 | Bus write strobe, active low, asynchronous |
| bus_oe_n | input | 1 | Bus read strobe, active low, asynchronous |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Bus write data |
| rd_data | output | DATA_W | Registered read data |
| rd_en | output | 1 | Read-data output enable |
| wr_valid | output | 1 | One-cycle pulse per committed write |
| wr_addr | output | ADDR_W | Address of the committed write |
| wr_data | output | DATA_W | Data of the committed write |

## Verification
Writes are driven in three strobe orderings: chip select first, write first, and both together. These show that the combined strobe, and not either pin alone, defines the window. Write pulses with chip select idle, both multi-cycle and sub-cycle, separate correct gating from edge detection on the raw write pin. A write strobe held low across one or two chip-select pulses separates "one commit per combined assertion" from "one commit per write edge". Changing the data mid-window and writing an out-of-range address show which sample is committed and that full decode is applied. Every write is confirmed by reading it back through the read strobe.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  // Synchronized bus strobes, active high after inversion of the pins.
  typedef struct packed {
    logic cs;
    logic we;
    logic oe;
  } xbs_strobe_t;
endpackage

// File: rtl/xbs_sync.sv
module xbs_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= '0;
          else     stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= '0;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/xbs_wr_capture.sv
module xbs_wr_capture #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NUM_REGS = 8,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              commit,
  output logic [IDX_W-1:0]  commit_idx,
  output logic [DATA_W-1:0] commit_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic              strobe;
  logic              strobe_q;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic              in_range;

  assign strobe   = cs & we;
  assign in_range = (cap_addr[ADDR_W-1:IDX_W] == '0);
  assign commit   = strobe_q & ~strobe & in_range;
  assign commit_idx  = cap_addr[IDX_W-1:0];
  assign commit_data = cap_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      strobe_q <= strobe;
      if (strobe) begin
        cap_addr <= addr;
        cap_data <= data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= commit;
      if (commit) begin
        wr_addr <= cap_addr;
        wr_data <= cap_data;
      end
    end
  end
endmodule

// File: rtl/xbs_regbank.sv
module xbs_regbank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NUM_REGS = 8,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wen,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_act,
  input  logic [ADDR_W-1:0] raddr,
  output logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [NUM_REGS];
  logic              rd_ok;

  assign rd_ok = (raddr[ADDR_W-1:IDX_W] == '0);

  always_ff @(posedge clk) begin
    if (wen) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en   <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_en <= rd_act;
      if (rd_act && rd_ok) rd_data <= mem[raddr[IDX_W-1:0]];
      else                 rd_data <= '0;
    end
  end
endmodule

// File: rtl/xbus_reg_slave.sv
module xbus_reg_slave #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NUM_REGS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_en,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  import xbs_pkg::*;

  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int BUS_W = ADDR_W + DATA_W;

  xbs_strobe_t       pin_strb;
  xbs_strobe_t       syn_strb;
  logic [BUS_W-1:0]  bus_dly;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_data;
  logic              commit;
  logic [IDX_W-1:0]  commit_idx;
  logic [DATA_W-1:0] commit_data;

  assign pin_strb = '{cs: ~bus_cs_n, we: ~bus_we_n, oe: ~bus_oe_n};

  xbs_sync #(.WIDTH($bits(xbs_strobe_t)), .STAGES(SYNC_STAGES)) u_strb_sync (
    .clk(clk), .rst(rst), .d(pin_strb), .q(syn_strb)
  );

  // Address and data see the same delay as the strobes so samples stay aligned.
  xbs_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_bus_dly (
    .clk(clk), .rst(rst), .d({bus_addr, bus_wdata}), .q(bus_dly)
  );

  assign s_addr = bus_dly[BUS_W-1:DATA_W];
  assign s_data = bus_dly[DATA_W-1:0];

  xbs_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_wcap (
    .clk(clk), .rst(rst), .cs(syn_strb.cs), .we(syn_strb.we),
    .addr(s_addr), .data(s_data),
    .commit(commit), .commit_idx(commit_idx), .commit_data(commit_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  xbs_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst(rst), .wen(commit), .widx(commit_idx), .wdata(commit_data),
    .rd_act(syn_strb.cs & syn_strb.oe), .raddr(s_addr),
    .rd_en(rd_en), .rd_data(rd_data)
  );
endmodule

// File: rtl/xbs_checker.sv
module xbs_checker #(
  parameter int ADDR_W = 8,
  parameter int NUM_REGS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_cs_n,
  input logic              bus_oe_n,
  input logic              rd_en,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr
);
  logic [2:0] cs_hi_cnt;
  logic [2:0] rd_hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_hi_cnt <= 3'd7;
      rd_hi_cnt <= 3'd7;
    end else begin
      if (!bus_cs_n) cs_hi_cnt <= '0;
      else if (cs_hi_cnt != 3'd7) cs_hi_cnt <= cs_hi_cnt + 3'd1;
      if (!bus_cs_n && !bus_oe_n) rd_hi_cnt <= '0;
      else if (rd_hi_cnt != 3'd7) rd_hi_cnt <= rd_hi_cnt + 3'd1;
    end
  end

  // R1: reset clears the outputs
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!wr_valid && !rd_en));

  // R2: write-valid is a single-cycle pulse
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  // R7: committed addresses are always in range
  p_addr_range_r7: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_addr < NUM_REGS));

  // R9: read enable drops soon after chip select or read strobe release
  p_rd_drop_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_hi_cnt <= 3'd2));

  // R10: no write without recent chip-select activity
  p_cs_gated_r10: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (cs_hi_cnt <= 3'd3));
endmodule

bind xbus_reg_slave xbs_checker #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
  .rd_en(rd_en), .wr_valid(wr_valid), .wr_addr(wr_addr)
);

// File: tb/sim_xbus_reg_slave.sv
module sim_xbus_reg_slave;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_data;
  logic rd_en, wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0, fails = 0;
  int wr_cnt = 0;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_data;

  always #5 clk = ~clk;

  xbus_reg_slave u0 (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
    .bus_addr(addr), .bus_wdata(wdata), .rd_data(rd_data), .rd_en(rd_en),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk) begin
    if (wr_valid) begin
      wr_cnt    <= wr_cnt + 1;
      last_addr <= wr_addr;
      last_data <= wr_data;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // mode 0: both together, 1: chip select first, 2: write first
  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int mode);
    @(negedge clk);
    addr = a; wdata = d;
    if (mode == 0) begin cs_n = 0; we_n = 0; end
    else if (mode == 1) begin cs_n = 0; idle(2); we_n = 0; end
    else begin we_n = 0; idle(2); cs_n = 0; end
    idle(4);
    if (mode == 2) begin cs_n = 1; idle(1); we_n = 1; end
    else begin we_n = 1; idle(1); cs_n = 1; end
    idle(6);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic en);
    @(negedge clk);
    addr = a; cs_n = 0; oe_n = 0;
    idle(4);
    d = rd_data; en = rd_en;
  endtask

  task automatic read_release(input string req, input bit drop_cs);
    if (drop_cs) cs_n = 1; else oe_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req, rd_en, 0);
    cs_n = 1; oe_n = 1;
    idle(2);
  endtask

  task automatic expect_reg(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] d; logic en;
    bus_read(a, d, en);
    check(req, en, 1);
    check(req, d, exp);
    read_release("R9", 1);
  endtask

  task automatic t_reset;
    rst = 1; idle(3);
    check("R1", {rd_en, wr_valid}, 0);
    check("R1", rd_data, 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check("R1", {rd_en, wr_valid}, 0);
    idle(3);
  endtask

  task automatic t_orders;
    int c0 = wr_cnt;
    bus_write(8'd1, 32'h1111_0001, 0);
    check("R2", wr_cnt, c0 + 1);
    check("R2", {last_addr, last_data}, {8'd1, 32'h1111_0001});
    bus_write(8'd2, 32'h2222_0002, 1);
    check("R3", {last_addr, last_data}, {8'd2, 32'h2222_0002});
    bus_write(8'd3, 32'h3333_0003, 2);
    check("R3", {last_addr, last_data}, {8'd3, 32'h3333_0003});
    check("R3", wr_cnt, c0 + 3);
    expect_reg("R2", 8'd1, 32'h1111_0001);
    expect_reg("R3", 8'd2, 32'h2222_0002);
    expect_reg("R3", 8'd3, 32'h3333_0003);
  endtask

  task automatic t_splinter;
    int c0 = wr_cnt;
    @(negedge clk);
    addr = 8'd1; wdata = 32'hDEAD_BEEF;
    we_n = 0; idle(3); we_n = 1; idle(2);
    #2 we_n = 0; #2 we_n = 1;
    idle(6);
    check("R4", wr_cnt, c0);
    expect_reg("R4", 8'd1, 32'h1111_0001);
  endtask

  task automatic t_long_we;
    int c0 = wr_cnt;
    @(negedge clk);
    addr = 8'd4; wdata = 32'h4444_0004; we_n = 0; idle(2);
    cs_n = 0; idle(6); cs_n = 1; idle(3); we_n = 1; idle(6);
    check("R5", wr_cnt, c0 + 1);
    c0 = wr_cnt;
    @(negedge clk);
    addr = 8'd5; wdata = 32'h5555_0005; we_n = 0; idle(1);
    cs_n = 0; idle(4); cs_n = 1; idle(4);
    addr = 8'd6; wdata = 32'h6666_0006;
    cs_n = 0; idle(4); cs_n = 1; idle(3); we_n = 1; idle(6);
    check("R5", wr_cnt, c0 + 2);
    expect_reg("R5", 8'd5, 32'h5555_0005);
    expect_reg("R5", 8'd6, 32'h6666_0006);
  endtask

  task automatic t_last_sample;
    @(negedge clk);
    addr = 8'd7; wdata = 32'hAAAA_0007; cs_n = 0; we_n = 0; idle(3);
    wdata = 32'hBBBB_0007; idle(3);
    we_n = 1; idle(1); cs_n = 1; idle(6);
    check("R6", last_data, 32'hBBBB_0007);
    expect_reg("R6", 8'd7, 32'hBBBB_0007);
  endtask

  task automatic t_range;
    int c0 = wr_cnt;
    logic [DW-1:0] d; logic en;
    bus_write(8'd8, 32'h8888_0008, 0);
    check("R7", wr_cnt, c0);
    expect_reg("R7", 8'd0, 32'h0);
    bus_read(8'd9, d, en);
    check("R8", {en, d}, {1'b1, 32'h0});
    read_release("R9", 0);
  endtask

  initial begin
    t_reset;
    bus_write(8'd0, 32'h0, 0);
    t_orders;
    t_splinter;
    t_long_we;
    t_last_sample;
    t_range;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule